// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital half of a dual-slope integrating converter. It runs a fixed cycle of three phases: auto-zero, signal integrate and reference de-integrate. It drives the select lines of the analog switches, which are outside the block together with the integrator, the comparator and the reference. It watches the comparator to find the moment the integrator returns to zero. The number of clocks from the start of de-integration to that moment is the conversion magnitude. The input polarity sampled at the end of signal integration gives the sign.

One conversion always lasts exactly four integrate periods, whatever the input. De-integration keeps counting after the zero crossing, with the integrator held. Because of this, the integrate windows of successive conversions are evenly spaced. A later stage can then add an odd number of results to cancel a noise frequency that one window alone would not reject. If no crossing happens, the result is full scale with an over-range flag. The period T is 2^T_LOG2 clocks and defaults to 2048, which gives a 12-bit magnitude.

Top module: `dsq_sequencer`

## Requirements
- R1: A synchronous reset puts the block at the first auto-zero cycle with its counter at zero. It also clears res_mag_o, res_neg_o, res_ovr_o and res_valid_o to 0.
- R2: phase_o cycles through auto-zero (code 0) for T clocks, then signal integrate (code 1) for T clocks, then de-integrate (code 2) for 2T clocks. The cycle then repeats, so every conversion lasts 4T clocks whatever the inputs do.
- R3: sw_az_o is high exactly during auto-zero and sw_sig_o is high exactly during signal integrate.
- R4: pol_pos_i is sampled only on the last signal-integrate clock. During de-integrate, before the crossing, sw_ref_neg_o is high if that sample was 1 and sw_ref_pos_o is high if it was 0. The value of pol_pos_i on any other clock has no effect.
- R5: The magnitude is c, where c is the de-integrate clock index (0 to 2T-1) of the first clock on which cmp_zero_i is sampled high during de-integrate.
- R6: From the clock after the crossing until de-integrate ends, both reference selects are low and sw_hold_o is high. Later values of cmp_zero_i have no effect.
- R7: If no crossing is seen within the 2T de-integrate clocks, res_ovr_o is 1 and res_mag_o is all ones (2T-1). A crossing on the final clock gives 2T-1 with res_ovr_o at 0.
- R8: res_valid_o is high for exactly one clock, the first clock after de-integrate ends. In that same clock res_mag_o, res_ovr_o and res_neg_o take the new result, and the three hold it until the next result. res_neg_o is the inverse of the polarity sample.
- R9: cmp_zero_i has no effect outside de-integrate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_zero_i | input | 1 | Comparator: integrator has reached zero |
| pol_pos_i | input | 1 | Comparator sign: integrated input is positive |
| phase_o | output | 2 | Current phase: 0 auto-zero, 1 integrate, 2 de-integrate |
| sw_az_o | output | 1 | Auto-zero switch select |
| sw_sig_o | output | 1 | Signal input switch select |
| sw_ref_pos_o | output | 1 | Positive reference switch select |
| sw_ref_neg_o | output | 1 | Negative reference switch select |
| sw_hold_o | output | 1 | Integrator hold after the crossing |
| res_valid_o | output | 1 | One-clock result strobe |
| res_mag_o | output | T_LOG2+1 | Latched magnitude |
| res_neg_o | output | 1 | Latched sign: input was negative |
| res_ovr_o | output | 1 | Latched over-range flag |

## Verification
The switch selects and phase_o are decoded from registered state, so they change at the same edge that enters a phase. A crossing seen at de-integrate index c shows up on sw_hold_o one edge later, at index c+1. The result appears 4T edges after the conversion starts, at the first auto-zero clock of the next conversion. The bench keeps its own position counter from reset release. At each falling edge it works out the expected phase, switches and result for that position and compares them. It then drives the comparator and polarity for the next rising edge. It sweeps every crossing index from 0 to 2T, the last being no crossing, for both polarities, using T=8. Noise on the comparator and on the polarity input in the phases where they must be ignored checks R4, R6 and R9.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_SIG = 2'd1,
    PH_DEI = 2'd2
  } phase_e;

  function automatic phase_e dsq_next_phase(input phase_e cur);
    case (cur)
      PH_AZ:   return PH_SIG;
      PH_SIG:  return PH_DEI;
      default: return PH_AZ;
    endcase
  endfunction
endpackage

// File: rtl/dsq_phase_timer.sv
module dsq_phase_timer
  import dsq_pkg::*;
#(
  parameter int T_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  output phase_e            phase_o,
  output logic [T_LOG2:0]   cnt_o,
  output logic              last_o
);
  localparam int CW = T_LOG2 + 1;
  localparam logic [CW-1:0] T_LAST = CW'((1 << T_LOG2) - 1);
  localparam logic [CW-1:0] D_LAST = {CW{1'b1}};

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic            last_w;

  assign last_w = (phase_q == PH_DEI) ? (cnt_q == D_LAST) : (cnt_q == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else if (last_w) begin
      phase_q <= dsq_next_phase(phase_q);
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign last_o  = last_w;

  // R2
  wrap_to_az_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DEI && last_w) |=> (phase_q == PH_AZ && cnt_q == '0));
  // R2
  az_to_sig_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_AZ && last_w) |=> (phase_q == PH_SIG));
  // R2
  mid_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (!last_w) |=> $stable(phase_q));
endmodule

// File: rtl/dsq_deint_track.sv
module dsq_deint_track
  import dsq_pkg::*;
#(
  parameter int T_LOG2 = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_e          phase_i,
  input  logic [T_LOG2:0] cnt_i,
  input  logic            last_i,
  input  logic            cmp_zero_i,
  input  logic            pol_pos_i,
  output logic            pol_q_o,
  output logic            crossed_o,
  output logic            hit_now_o,
  output logic [T_LOG2:0] cap_o
);
  localparam int CW = T_LOG2 + 1;

  logic          pol_q;
  logic          crossed_q;
  logic [CW-1:0] cap_q;
  logic          hit_w;

  assign hit_w = (phase_i == PH_DEI) && !crossed_q && cmp_zero_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q     <= 1'b0;
      crossed_q <= 1'b0;
      cap_q     <= '0;
    end else begin
      if (phase_i == PH_SIG && last_i) pol_q <= pol_pos_i;
      if (phase_i != PH_DEI || last_i) begin
        crossed_q <= 1'b0;
      end else if (hit_w) begin
        crossed_q <= 1'b1;
        cap_q     <= cnt_i;
      end
    end
  end

  assign pol_q_o   = pol_q;
  assign crossed_o = crossed_q;
  assign hit_now_o = hit_w;
  assign cap_o     = cap_q;

  // R6
  crossed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_DEI && crossed_q && !last_i) |=> (crossed_q && $stable(cap_q)));
  // R4
  pol_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i != PH_SIG) |=> $stable(pol_q));
  // R9
  no_cross_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_AZ) |=> !crossed_q);
endmodule

// File: rtl/dsq_result_reg.sv
module dsq_result_reg
  import dsq_pkg::*;
#(
  parameter int T_LOG2 = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_end_i,
  input  logic            crossed_i,
  input  logic            hit_now_i,
  input  logic [T_LOG2:0] cap_i,
  input  logic [T_LOG2:0] cnt_i,
  input  logic            pol_q_i,
  output logic            valid_o,
  output logic [T_LOG2:0] mag_o,
  output logic            neg_o,
  output logic            ovr_o
);
  localparam int CW = T_LOG2 + 1;

  function automatic logic [CW-1:0] pick_mag(input logic crossed, input logic hit,
                                             input logic [CW-1:0] cap,
                                             input logic [CW-1:0] cnt);
    if (crossed) return cap;
    if (hit)     return cnt;
    return {CW{1'b1}};
  endfunction

  logic          valid_q, neg_q, ovr_q;
  logic [CW-1:0] mag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= conv_end_i;
      if (conv_end_i) begin
        mag_q <= pick_mag(crossed_i, hit_now_i, cap_i, cnt_i);
        ovr_q <= !(crossed_i || hit_now_i);
        neg_q <= !pol_q_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign mag_o   = mag_q;
  assign neg_o   = neg_q;
  assign ovr_o   = ovr_q;

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_end_i) |=> ($stable(mag_q) && $stable(ovr_q) && $stable(neg_q)));
  // R7
  ovr_fullscale_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ovr_q) |-> (&mag_q));
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int T_LOG2 = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_zero_i,
  input  logic            pol_pos_i,
  output logic [1:0]      phase_o,
  output logic            sw_az_o,
  output logic            sw_sig_o,
  output logic            sw_ref_pos_o,
  output logic            sw_ref_neg_o,
  output logic            sw_hold_o,
  output logic            res_valid_o,
  output logic [T_LOG2:0] res_mag_o,
  output logic            res_neg_o,
  output logic            res_ovr_o
);
  localparam int CW = T_LOG2 + 1;

  phase_e        phase_w;
  logic [CW-1:0] cnt_w;
  logic          last_w;
  logic          pol_q_w, crossed_w, hit_w;
  logic [CW-1:0] cap_w;
  logic          conv_end_w;

  dsq_phase_timer #(.T_LOG2(T_LOG2)) timer_i (
    .clk(clk), .rst(rst), .phase_o(phase_w), .cnt_o(cnt_w), .last_o(last_w)
  );

  dsq_deint_track #(.T_LOG2(T_LOG2)) track_i (
    .clk(clk), .rst(rst), .phase_i(phase_w), .cnt_i(cnt_w), .last_i(last_w),
    .cmp_zero_i(cmp_zero_i), .pol_pos_i(pol_pos_i),
    .pol_q_o(pol_q_w), .crossed_o(crossed_w), .hit_now_o(hit_w), .cap_o(cap_w)
  );

  assign conv_end_w = (phase_w == PH_DEI) && last_w;

  dsq_result_reg #(.T_LOG2(T_LOG2)) result_i (
    .clk(clk), .rst(rst), .conv_end_i(conv_end_w), .crossed_i(crossed_w),
    .hit_now_i(hit_w), .cap_i(cap_w), .cnt_i(cnt_w), .pol_q_i(pol_q_w),
    .valid_o(res_valid_o), .mag_o(res_mag_o), .neg_o(res_neg_o), .ovr_o(res_ovr_o)
  );

  assign phase_o      = phase_w;
  assign sw_az_o      = (phase_w == PH_AZ);
  assign sw_sig_o     = (phase_w == PH_SIG);
  assign sw_ref_neg_o = (phase_w == PH_DEI) && !crossed_w && pol_q_w;
  assign sw_ref_pos_o = (phase_w == PH_DEI) && !crossed_w && !pol_q_w;
  assign sw_hold_o    = (phase_w == PH_DEI) && crossed_w;

  // R3
  switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sw_az_o, sw_sig_o, sw_ref_pos_o, sw_ref_neg_o, sw_hold_o}));
  // R8
  valid_after_deint_chk: assert property (@(posedge clk) disable iff (rst)
    conv_end_w |=> (res_valid_o && phase_w == PH_AZ));
  // R6
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_hold_o && !last_w) |=> sw_hold_o);
endmodule

// File: tb/dsq_sequencer_tb.sv
`timescale 1ns/1ps
module dsq_sequencer_tb_top;
  localparam int TL = 3;
  localparam int T  = 1 << TL;
  localparam int CW = TL + 1;
  localparam int FS = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_zero = 1'b0;
  logic pol_pos = 1'b0;
  logic [1:0] phase;
  logic sw_az, sw_sig, sw_rp, sw_rn, sw_hold, res_valid, res_neg, res_ovr;
  logic [CW-1:0] res_mag;

  int n_cmp = 0;
  int n_bad = 0;
  int have_prev = 0;
  int prev_m = 0;
  int prev_pl = 0;
  int e_mag = 0;
  int e_neg = 0;
  int e_ovr = 0;

  always #2.5 clk = ~clk;

  dsq_sequencer #(.T_LOG2(TL)) dut_i (
    .clk(clk), .rst(rst), .cmp_zero_i(cmp_zero), .pol_pos_i(pol_pos),
    .phase_o(phase), .sw_az_o(sw_az), .sw_sig_o(sw_sig), .sw_ref_pos_o(sw_rp),
    .sw_ref_neg_o(sw_rn), .sw_hold_o(sw_hold), .res_valid_o(res_valid),
    .res_mag_o(res_mag), .res_neg_o(res_neg), .res_ovr_o(res_ovr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Runs one conversion with crossing index m (2T means none) and polarity pl,
  // stopping before position stop_at. Called at a falling edge.
  task automatic run_conv(input int m, input int pl, input int stop_at);
    for (int p = 0; p < stop_at; p++) begin
      int ph, c;
      ph = (p < T) ? 0 : (p < 2*T) ? 1 : 2;
      c  = (ph == 2) ? p - 2*T : (ph == 1) ? p - T : p;
      if (p == 0 && have_prev != 0) begin
        e_mag = (prev_m >= 2*T) ? FS : prev_m;
        e_ovr = (prev_m >= 2*T) ? 1 : 0;
        e_neg = (prev_pl != 0) ? 0 : 1;
      end
      chk("R2 phase", int'(phase), ph);
      chk("R3 sw_az", int'(sw_az), int'(ph == 0));
      chk("R3 sw_sig", int'(sw_sig), int'(ph == 1));
      chk("R4 sw_ref_neg", int'(sw_rn), int'(ph == 2 && c <= m && pl != 0));
      chk("R4 sw_ref_pos", int'(sw_rp), int'(ph == 2 && c <= m && pl == 0));
      chk("R6 sw_hold", int'(sw_hold), int'(ph == 2 && c > m));
      chk("R8 res_valid", int'(res_valid), int'(p == 0 && have_prev != 0));
      chk("R5,R9 res_mag", int'(res_mag), e_mag);
      chk("R7 res_ovr", int'(res_ovr), e_ovr);
      chk("R8 res_neg", int'(res_neg), e_neg);
      // R4: polarity noise everywhere except the last integrate clock
      pol_pos  = (ph == 1 && c == T-1) ? (pl != 0) : (((p >> 1) ^ p) & 1) != 0;
      // R9: comparator noise outside de-integrate; R6: chatter after the crossing
      cmp_zero = (ph == 2) ? (c == m || (c > m && (c & 1) != 0)) : ((p & 1) != 0);
      @(posedge clk);
      @(negedge clk);
    end
    have_prev = 1;
    prev_m = m;
    prev_pl = pl;
  endtask

  task automatic chk_reset_state();
    chk("R1 phase", int'(phase), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 res_mag", int'(res_mag), 0);
    chk("R1 res_ovr", int'(res_ovr), 0);
    chk("R1 res_neg", int'(res_neg), 0);
    chk("R1 sw_az", int'(sw_az), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_reset_state();
    for (int pl = 0; pl < 2; pl++)
      for (int m = 0; m <= 2*T; m++)
        run_conv(m, pl, 4*T);
    run_conv(3, 1, 2*T + 4);
    // R1: reset in the middle of de-integrate restarts the sequence
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    have_prev = 0;
    e_mag = 0; e_ovr = 0; e_neg = 0;
    chk_reset_state();
    run_conv(5, 0, 4*T);
    run_conv(2*T - 1, 1, 4*T);
    run_conv(0, 0, 1);
    summary();
  end
endmodule